// File: doc/BRIEF.md
# Counted Watchpoint and Breakpoint Unit

This debug block watches three buses of a processor: the fetch address, the load/store effective address and the load/store data. Eight comparators each hold a programmed value and a relation. Four of them look at the fetch address. Two look at the load/store address and two look at the load/store data. A comparator can test for equality, inequality, greater-than or less-than, and every test is unsigned. A comparator only reports a hit on a cycle when the valid strobe of its bus is high.

The comparator hits are combined into six watchpoint events. Each fetch comparator drives its own event. Each load/store lane pairs one address comparator with one data comparator. The lane either takes the OR of the two hits or, when qualified, needs both to hit at once. The events appear on the watchpoint outputs. Each event also feeds a 16-bit occurrence counter, which raises a breakpoint pulse on the Nth event and then starts again. Software configures the unit through a single-cycle register write port.

Top module: `watch_break_unit`

## Requirements
- R1: After reset, wp_o and bp_o are 0, every comparator is disabled, and no bus activity raises an output until it is configured.
- R2: Comparator k (0..7) has its value register at address k and its control register at address 8+k. Control bits [1:0] select the relation (00 equal, 01 not equal, 10 operand greater than value, 11 operand less than value, all unsigned), and bit 2 enables the comparator.
- R3: Comparators 0..3 observe if_addr_i. A hit on comparator k sets wp_o[k] in the cycle after a fetch with if_valid_i high. No hit occurs while if_valid_i is low.
- R4: Comparators 4 and 5 observe ls_addr_i, and comparators 6 and 7 observe ls_data_i, all gated by ls_valid_i. Lane j (0..1) pairs comparator 4+j with comparator 6+j and drives wp_o[4+j] one cycle later. When the lane is unqualified, it fires on a hit of either comparator.
- R5: Bit 3 of the control register of data comparator 6+j qualifies lane j. A qualified lane fires only when both the address comparator and the data comparator hit in the same cycle.
- R6: Counter j has its register at address 16+j, with the reload in bits [15:0] and the breakpoint enable in bit 16. When enabled with reload N (N≥1), bp_o[j] pulses for one cycle on the Nth event of watchpoint j, in the same cycle as that event's wp_o[j], and the count then restarts. A reload of 0 acts as 1.
- R7: While the breakpoint enable bit is clear, bp_o[j] stays low. Cycles without an event never advance a counter.
- R8: Writing a counter register restarts its count from the new reload. If an event arrives in the same cycle as the write, the write wins and that event is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 5 | Configuration register address |
| cfg_wdata_i | input | 32 | Configuration write data |
| if_valid_i | input | 1 | Fetch address valid |
| if_addr_i | input | 32 | Fetch address |
| ls_valid_i | input | 1 | Load/store access valid |
| ls_addr_i | input | 32 | Load/store effective address |
| ls_data_i | input | 32 | Load/store data |
| wp_o | output | 6 | Registered watchpoint events |
| bp_o | output | 6 | Registered breakpoint pulses |

## Verification
The bench probes each relation on both sides of the programmed value. One probe uses an operand with its top bit set, so a signed less-than would show up as a false hit. It steps the load/store lanes through address-only, data-only and combined matches in both qualification modes. An OR/AND mix-up therefore shows as a wrong wp_o[4] bit. The counters are checked for firing on exactly the Nth event and reloading afterwards. They are also checked for not counting cycles with the strobe low, and for letting a write override a same-cycle event. An off-by-one, a missing reload or a wrong priority in the counter would shift the bp_o pulse in the checked sequence.

// File: rtl/wb_pkg.sv
package wb_pkg;
  typedef enum logic [1:0] {
    REL_EQ = 2'b00,
    REL_NE = 2'b01,
    REL_GT = 2'b10,
    REL_LT = 2'b11
  } rel_e;

  localparam int unsigned CTL_EN_BIT   = 2;
  localparam int unsigned CTL_QUAL_BIT = 3;
endpackage

// File: rtl/wb_cmp.sv
module wb_cmp #(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            val_we_i,
  input  logic            ctl_we_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic [XLEN-1:0] opnd_i,
  input  logic            valid_i,
  output logic            hit_o
);
  import wb_pkg::*;

  logic [XLEN-1:0] val_q;
  rel_e            rel_q;
  logic            en_q;
  logic            rel_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q <= '0;
      rel_q <= REL_EQ;
      en_q  <= 1'b0;
    end else begin
      if (val_we_i) val_q <= wdata_i;
      if (ctl_we_i) begin
        rel_q <= rel_e'(wdata_i[1:0]);
        en_q  <= wdata_i[CTL_EN_BIT];
      end
    end
  end

  always_comb begin
    unique case (rel_q)
      REL_EQ:  rel_ok = (opnd_i == val_q);
      REL_NE:  rel_ok = (opnd_i != val_q);
      REL_GT:  rel_ok = (opnd_i >  val_q);
      default: rel_ok = (opnd_i <  val_q);
    endcase
  end

  assign hit_o = en_q & valid_i & rel_ok;
endmodule

// File: rtl/wb_route.sv
module wb_route (
  input  logic la_hit_i,
  input  logic ld_hit_i,
  input  logic qual_i,
  output logic evt_o
);
  assign evt_o = qual_i ? (la_hit_i & ld_hit_i) : (la_hit_i | ld_hit_i);
endmodule

// File: rtl/wb_cnt.sv
module wb_cnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cfg_we_i,
  input  logic [CNT_W:0] cfg_wdata_i,
  input  logic           evt_i,
  output logic           fire_o
);
  logic [CNT_W-1:0] reload_q, cnt_q;
  logic             en_q, fire_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_q <= '0;
      cnt_q    <= '0;
      en_q     <= 1'b0;
      fire_q   <= 1'b0;
    end else begin
      fire_q <= 1'b0;
      if (cfg_we_i) begin
        reload_q <= cfg_wdata_i[CNT_W-1:0];
        cnt_q    <= cfg_wdata_i[CNT_W-1:0];
        en_q     <= cfg_wdata_i[CNT_W];
      end else if (evt_i && en_q) begin
        if (cnt_q <= CNT_W'(1)) begin
          fire_q <= 1'b1;
          cnt_q  <= reload_q;
        end else begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
      end
    end
  end

  assign fire_o = fire_q;

  // R6
  fire_after_evt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |-> $past(evt_i && en_q && !cfg_we_i));
  // R6
  cnt_le_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= reload_q);
  // R7
  no_fire_disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |=> !fire_o);
endmodule

// File: rtl/watch_break_unit.sv
module watch_break_unit #(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned N_IA   = 4,
  parameter int unsigned N_LS   = 2,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned CFG_AW = 5,
  localparam int unsigned N_CMP = N_IA + 2 * N_LS,
  localparam int unsigned N_WP  = N_IA + N_LS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [XLEN-1:0]   cfg_wdata_i,
  input  logic              if_valid_i,
  input  logic [XLEN-1:0]   if_addr_i,
  input  logic              ls_valid_i,
  input  logic [XLEN-1:0]   ls_addr_i,
  input  logic [XLEN-1:0]   ls_data_i,
  output logic [N_WP-1:0]   wp_o,
  output logic [N_WP-1:0]   bp_o
);
  import wb_pkg::*;

  localparam int unsigned CTL_BASE = N_CMP;
  localparam int unsigned CNT_BASE = 2 * N_CMP;

  logic [XLEN-1:0] opnd [N_CMP];
  logic [N_CMP-1:0] vld, hit;
  logic [N_WP-1:0]  evt, wp_q;
  logic [N_LS-1:0]  qual_q;

  for (genvar k = 0; k < N_CMP; k++) begin : g_cmp
    if (k < N_IA) begin : g_if
      assign opnd[k] = if_addr_i;
      assign vld[k]  = if_valid_i;
    end else if (k < N_IA + N_LS) begin : g_la
      assign opnd[k] = ls_addr_i;
      assign vld[k]  = ls_valid_i;
    end else begin : g_ld
      assign opnd[k] = ls_data_i;
      assign vld[k]  = ls_valid_i;
    end

    wb_cmp #(.XLEN(XLEN)) u_cmp (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .val_we_i (cfg_we_i && cfg_addr_i == CFG_AW'(k)),
      .ctl_we_i (cfg_we_i && cfg_addr_i == CFG_AW'(CTL_BASE + k)),
      .wdata_i  (cfg_wdata_i),
      .opnd_i   (opnd[k]),
      .valid_i  (vld[k]),
      .hit_o    (hit[k])
    );
  end

  for (genvar k = 0; k < N_IA; k++) begin : g_ia_evt
    assign evt[k] = hit[k];
  end

  for (genvar j = 0; j < N_LS; j++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) qual_q[j] <= 1'b0;
      else if (cfg_we_i && cfg_addr_i == CFG_AW'(CTL_BASE + N_IA + N_LS + j))
        qual_q[j] <= cfg_wdata_i[CTL_QUAL_BIT];
    end

    wb_route u_route (
      .la_hit_i (hit[N_IA + j]),
      .ld_hit_i (hit[N_IA + N_LS + j]),
      .qual_i   (qual_q[j]),
      .evt_o    (evt[N_IA + j])
    );
  end

  for (genvar j = 0; j < N_WP; j++) begin : g_cnt
    wb_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .cfg_we_i    (cfg_we_i && cfg_addr_i == CFG_AW'(CNT_BASE + j)),
      .cfg_wdata_i (cfg_wdata_i[CNT_W:0]),
      .evt_i       (evt[j]),
      .fire_o      (bp_o[j])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wp_q <= '0;
    else         wp_q <= evt;
  end

  assign wp_o = wp_q;

  // R3
  if_valid_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|wp_q[N_IA-1:0]) |-> $past(if_valid_i));
  // R4
  ls_valid_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|wp_q[N_WP-1:N_IA]) |-> $past(ls_valid_i));
  // R6
  bp_with_wp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bp_o & ~wp_o) == '0);
endmodule

// File: tb/watch_break_unit_test.sv
`timescale 1ns/1ps
module watch_break_unit_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [4:0]  cfg_addr_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic        if_valid_i = 1'b0;
  logic [31:0] if_addr_i = '0;
  logic        ls_valid_i = 1'b0;
  logic [31:0] ls_addr_i = '0;
  logic [31:0] ls_data_i = '0;
  logic [5:0]  wp_o, bp_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [5:0] wp_s, bp_s;

  watch_break_unit uut (.*);

  always #10 clk_i = ~clk_i;

  task automatic chk(string req, logic [5:0] act, logic [5:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic obs(logic ifv, logic [31:0] ifa, logic lsv, logic [31:0] lsa, logic [31:0] lsd);
    @(negedge clk_i);
    if_valid_i = ifv; if_addr_i = ifa;
    ls_valid_i = lsv; ls_addr_i = lsa; ls_data_i = lsd;
    @(posedge clk_i); #2;
    wp_s = wp_o; bp_s = bp_o;
    @(negedge clk_i);
    if_valid_i = 1'b0; ls_valid_i = 1'b0;
  endtask

  task automatic clear_all();
    for (int k = 0; k < 8; k++) wr(5'(8 + k), 32'h0);
    for (int j = 0; j < 6; j++) wr(5'(16 + j), 32'h0);
  endtask

  task automatic t_reset();
    chk("R1 reset wp", wp_o, 6'h0);
    chk("R1 reset bp", bp_o, 6'h0);
    obs(1'b1, 32'h0, 1'b1, 32'h0, 32'h0);
    chk("R1 disabled wp", wp_s, 6'h0);
    chk("R1 disabled bp", bp_s, 6'h0);
  endtask

  task automatic t_rel();
    clear_all();
    wr(5'd0, 32'd100);
    wr(5'd8, 32'h4);                       // eq
    obs(1'b1, 32'd100, 1'b0, 0, 0); chk("R2 eq hit", wp_s, 6'h01);
    obs(1'b1, 32'd99, 1'b0, 0, 0);  chk("R2 eq miss", wp_s, 6'h00);
    wr(5'd8, 32'h5);                       // ne
    obs(1'b1, 32'd99, 1'b0, 0, 0);  chk("R2 ne hit", wp_s, 6'h01);
    obs(1'b1, 32'd100, 1'b0, 0, 0); chk("R2 ne miss", wp_s, 6'h00);
    wr(5'd8, 32'h6);                       // gt
    obs(1'b1, 32'd101, 1'b0, 0, 0); chk("R2 gt hit", wp_s, 6'h01);
    obs(1'b1, 32'd100, 1'b0, 0, 0); chk("R2 gt miss", wp_s, 6'h00);
    wr(5'd8, 32'h7);                       // lt
    obs(1'b1, 32'd99, 1'b0, 0, 0);  chk("R2 lt hit", wp_s, 6'h01);
    obs(1'b1, 32'hFFFF_FFFF, 1'b0, 0, 0); chk("R2 lt unsigned", wp_s, 6'h00);
  endtask

  task automatic t_if();
    clear_all();
    wr(5'd1, 32'h200); wr(5'd9, 32'h4);
    wr(5'd3, 32'h300); wr(5'd11, 32'h4);
    obs(1'b0, 32'h200, 1'b0, 0, 0); chk("R3 valid low", wp_s, 6'h00);
    obs(1'b1, 32'h200, 1'b0, 0, 0); chk("R3 comp1", wp_s, 6'h02);
    obs(1'b1, 32'h300, 1'b0, 0, 0); chk("R3 comp3", wp_s, 6'h08);
  endtask

  task automatic t_lane();
    clear_all();
    wr(5'd4, 32'hA0); wr(5'd12, 32'h4);
    wr(5'd6, 32'hD0); wr(5'd14, 32'h4);    // unqualified
    obs(1'b0, 0, 1'b1, 32'hA0, 32'h1);  chk("R4 addr only", wp_s, 6'h10);
    obs(1'b0, 0, 1'b1, 32'h1, 32'hD0);  chk("R4 data only", wp_s, 6'h10);
    obs(1'b0, 0, 1'b0, 32'hA0, 32'hD0); chk("R4 ls valid low", wp_s, 6'h00);
    obs(1'b1, 32'hA0, 1'b0, 0, 0);      chk("R4 fetch ignored", wp_s, 6'h00);
    wr(5'd14, 32'hC);                      // qualified
    obs(1'b0, 0, 1'b1, 32'hA0, 32'h1);  chk("R5 addr only", wp_s, 6'h00);
    obs(1'b0, 0, 1'b1, 32'h1, 32'hD0);  chk("R5 data only", wp_s, 6'h00);
    obs(1'b0, 0, 1'b1, 32'hA0, 32'hD0); chk("R5 both", wp_s, 6'h10);
  endtask

  task automatic t_count();
    logic [5:0] exp;
    clear_all();
    wr(5'd0, 32'h40); wr(5'd8, 32'h4);
    wr(5'd16, 32'h1_0003);
    for (int i = 1; i <= 6; i++) begin
      obs(1'b1, 32'h40, 1'b0, 0, 0);
      exp = (i % 3 == 0) ? 6'h01 : 6'h00;
      chk("R6 count3 bp", bp_s, exp);
      chk("R6 count3 wp", wp_s, 6'h01);
    end
    wr(5'd16, 32'h1_0000);
    obs(1'b1, 32'h40, 1'b0, 0, 0); chk("R6 reload0 first", bp_s, 6'h01);
    obs(1'b1, 32'h40, 1'b0, 0, 0); chk("R6 reload0 second", bp_s, 6'h01);
  endtask

  task automatic t_disable();
    clear_all();
    wr(5'd0, 32'h40); wr(5'd8, 32'h4);
    wr(5'd16, 32'h0_0001);
    for (int i = 0; i < 3; i++) begin
      obs(1'b1, 32'h40, 1'b0, 0, 0); chk("R7 disabled bp", bp_s, 6'h00);
    end
    wr(5'd16, 32'h1_0002);
    for (int i = 0; i < 3; i++) begin
      obs(1'b0, 32'h40, 1'b0, 0, 0); chk("R7 no event no count", bp_s, 6'h00);
    end
    obs(1'b1, 32'h40, 1'b0, 0, 0); chk("R7 first event", bp_s, 6'h00);
    obs(1'b1, 32'h40, 1'b0, 0, 0); chk("R7 second event", bp_s, 6'h01);
  endtask

  task automatic t_wr_wins();
    clear_all();
    wr(5'd0, 32'h40); wr(5'd8, 32'h4);
    wr(5'd16, 32'h1_0002);
    obs(1'b1, 32'h40, 1'b0, 0, 0); chk("R8 event1", bp_s, 6'h00);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_addr_i = 5'd16; cfg_wdata_i = 32'h1_0002;
    if_valid_i = 1'b1; if_addr_i = 32'h40;
    @(posedge clk_i); #2;
    chk("R8 write with event", bp_o, 6'h00);
    @(negedge clk_i);
    cfg_we_i = 1'b0; if_valid_i = 1'b0;
    obs(1'b1, 32'h40, 1'b0, 0, 0); chk("R8 restart first", bp_s, 6'h00);
    obs(1'b1, 32'h40, 1'b0, 0, 0); chk("R8 restart second", bp_s, 6'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #3;
    t_reset();
    t_rel();
    t_if();
    t_lane();
    t_count();
    t_disable();
    t_wr_wins();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule